// File: doc/BRIEF.md
# Trap and interrupt control unit

This unit keeps the privileged control state of a small in-order core: a status word, a cause word, the saved exception PC, the vector base, the captured bad address, and an instruction counter with a compare register. In each cycle it combines a synchronous exception request from the pipeline with any pending interrupt that the status word allows. In that same cycle it says whether the pipeline must redirect, and to which vector. At the next clock edge it commits the trap: it saves the PC and the bad address, rewrites the cause code and moves the status word into supervisor mode.

When a trap arrives while trap-taking is disabled, or when its code lies outside the defined range, the unit does not redirect. It latches a sticky fatal flag instead. The unit also drives the effective register width, the supervisor and translation-enable levels and a TLB flush pulse toward the memory unit. Software reaches the registers through one write strobe, a 3-bit address and a read-data port decoded from the same address.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, status reads 0x000000A0 (supervisor bit 5 and supervisor-wide bit 7), and cause, exception PC, vector, bad address, count and compare read 0. fatal_o and trap_o are low, wide_o and sup_o are high, and vm_en_o is low. CSR addresses: 0 status, 1 cause, 2 exception PC, 3 vector, 4 bad address (read-only), 5 count, 6 compare.
- R2: An interrupt is requested when retire_i is high, status bit 0 (trap enable) is set, and the AND of cause[23:16] (pending) with status[23:16] (mask) is nonzero. In that same cycle trap_o rises with trap_code_o = 15 and trap_vec_o equal to the vector register.
- R3: At a taken trap, status bit 0 clears, bit 5 sets, and bit 4 (previous supervisor) takes the old bit 5. All other status bits keep their values.
- R4: At a taken trap, cause[4:0] takes the trap code, cause[23:16] is kept, the exception PC takes pc_i, and the bad address takes bad_addr_i.
- R5: An exception request made while status bit 0 is clear, or with a code of 16 or more, keeps trap_o low, leaves the registers unchanged and sets fatal_o. fatal_o stays set until reset, and no trap is taken while it is set.
- R6: The counter increments on each cycle with retire_i high. When its value before the increment equals compare, the timer pending bit cause[23] is set at the same edge.
- R7: A software write to cause replaces cause[23:16] with the written bits, with bit 23 forced to 0, and leaves the code unchanged. A timer match in the same cycle sets bit 23 anyway.
- R8: A status write keeps only bits 0 to 8 and 23:16. With the default configuration, the compressed-instruction enable (bit 2) and the vector enable (bit 3) also read 0. Bit 1 is the float enable, bit 6 the user-wide bit and bit 8 the translation enable.
- R9: wide_o is status bit 7 when bit 5 is set, and status bit 6 otherwise.
- R10: A status write or a taken trap pulses tlb_flush_o high for one cycle after the edge. sup_o and vm_en_o show status bits 5 and 8 from that same cycle.
- R11: An exception and an interrupt in the same cycle take the exception's code, and the interrupt's pending bit stays set.
- R12: A CSR write in a cycle where a trap is taken is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| retire_i | input | 1 | An instruction retires this cycle |
| pc_i | input | XLEN | PC of the instruction at the trap point |
| exc_valid_i | input | 1 | Synchronous exception request |
| exc_code_i | input | CODE_W | Exception trap code |
| bad_addr_i | input | XLEN | Faulting address from the memory unit |
| csr_we_i | input | 1 | Control register write strobe |
| csr_addr_i | input | 3 | Control register select for writes and reads |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data for csr_addr_i |
| trap_o | output | 1 | Redirect the pipeline this cycle |
| trap_code_o | output | CODE_W | Code of the trap being requested |
| trap_vec_o | output | XLEN | Redirect target |
| fatal_o | output | 1 | Sticky fatal error mode |
| wide_o | output | 1 | Effective register width is 64 |
| sup_o | output | 1 | Supervisor mode |
| vm_en_o | output | 1 | Address translation enabled |
| tlb_flush_o | output | 1 | One-cycle TLB flush pulse |

## Verification
The bench goes after the collision cases. With an exception and an interrupt in one cycle, a design with the priority reversed records code 15 and loses the exception. A timer match in the same cycle as a software cause write, if mishandled, drops the timer interrupt. A CSR write in a trap cycle, if not dropped, overwrites the saved PC. The bench also checks previous-supervisor capture from both user and supervisor mode, since a wrong capture breaks the return path. A trap made with trap-enable clear, and an out-of-range code, must end in fatal mode and not in a redirect. A design that vectored there would show trap_o high and a changed exception PC.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [2:0] CSR_STATUS  = 3'd0;
  localparam logic [2:0] CSR_CAUSE   = 3'd1;
  localparam logic [2:0] CSR_EPC     = 3'd2;
  localparam logic [2:0] CSR_EVEC    = 3'd3;
  localparam logic [2:0] CSR_BADADDR = 3'd4;
  localparam logic [2:0] CSR_COUNT   = 3'd5;
  localparam logic [2:0] CSR_COMPARE = 3'd6;

  localparam int ST_TE     = 0;  // trap enable
  localparam int ST_FP     = 1;
  localparam int ST_SH     = 2;
  localparam int ST_VE     = 3;
  localparam int ST_PS     = 4;
  localparam int ST_SU     = 5;
  localparam int ST_UW     = 6;
  localparam int ST_SW     = 7;
  localparam int ST_VM     = 8;
  localparam int ST_IM_LSB = 16;
  localparam int CA_IP_LSB = 16;
endpackage

// File: rtl/trap_status.sv
module trap_status import trap_pkg::*; #(
  parameter int XLEN      = 32,
  parameter int IRQ_W     = 8,
  parameter bit HAS_W64   = 1'b1,
  parameter bit HAS_FLOAT = 1'b1,
  parameter bit HAS_SHORT = 1'b0,
  parameter bit HAS_VEC   = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            trap_i,
  output logic [XLEN-1:0] status_o,
  output logic            flush_o
);
  function automatic logic [XLEN-1:0] keep_mask();
    logic [XLEN-1:0] m;
    m = '0;
    m[ST_IM_LSB +: IRQ_W] = '1;
    m[ST_VM:ST_TE] = '1;
    if (!HAS_W64) begin
      m[ST_SW] = 1'b0;
      m[ST_UW] = 1'b0;
    end
    if (!HAS_FLOAT) m[ST_FP] = 1'b0;
    if (!HAS_SHORT) m[ST_SH] = 1'b0;
    if (!HAS_VEC)   m[ST_VE] = 1'b0;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] reset_value();
    logic [XLEN-1:0] r;
    r = '0;
    r[ST_SU] = 1'b1;
    r[ST_SW] = HAS_W64;
    return r;
  endfunction

  localparam logic [XLEN-1:0] KeepMask = keep_mask();
  localparam logic [XLEN-1:0] RstVal   = reset_value();

  logic [XLEN-1:0] st_q;
  logic            flush_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RstVal;
      flush_q <= 1'b0;
    end else begin
      flush_q <= trap_i | wr_i;
      if (trap_i) begin
        st_q[ST_TE] <= 1'b0;
        st_q[ST_SU] <= 1'b1;
        st_q[ST_PS] <= st_q[ST_SU];
      end else if (wr_i) begin
        st_q <= wdata_i & KeepMask;
      end
    end
  end

  assign status_o = st_q;
  assign flush_o  = flush_q;
endmodule

// File: rtl/trap_timer.sv
module trap_timer #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            retire_i,
  input  logic            cnt_wr_i,
  input  logic            cmp_wr_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] count_o,
  output logic [XLEN-1:0] compare_o,
  output logic            hit_o
);
  logic [XLEN-1:0] cnt_q, cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      if (cnt_wr_i)      cnt_q <= wdata_i;
      else if (retire_i) cnt_q <= cnt_q + 1'b1;
      if (cmp_wr_i)      cmp_q <= wdata_i;
    end
  end

  // match on the pre-increment value
  assign hit_o     = retire_i && (cnt_q == cmp_q);
  assign count_o   = cnt_q;
  assign compare_o = cmp_q;
endmodule

// File: rtl/trap_decide.sv
module trap_decide import trap_pkg::*; #(
  parameter int XLEN      = 32,
  parameter int IRQ_W     = 8,
  parameter int CODE_W    = 5,
  parameter int NUM_TRAPS = 16,
  parameter int IRQ_CODE  = 15
) (
  input  logic [XLEN-1:0]   status_i,
  input  logic [IRQ_W-1:0]  pend_i,
  input  logic              fatal_i,
  input  logic              retire_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  output logic              take_o,
  output logic [CODE_W-1:0] code_o,
  output logic              error_o
);
  logic te, irq, bad;

  assign te  = status_i[ST_TE];
  assign irq = retire_i && te && |(pend_i & status_i[ST_IM_LSB +: IRQ_W]);
  assign bad = exc_valid_i && (!te || (int'(exc_code_i) >= NUM_TRAPS));

  // exception wins over interrupt
  assign code_o  = exc_valid_i ? exc_code_i : CODE_W'(IRQ_CODE);
  assign take_o  = (exc_valid_i || irq) && !bad && !fatal_i;
  assign error_o = bad;
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl import trap_pkg::*; #(
  parameter int XLEN      = 32,
  parameter int IRQ_W     = 8,
  parameter int CODE_W    = 5,
  parameter int NUM_TRAPS = 16,
  parameter int IRQ_CODE  = 15,
  parameter int TIMER_BIT = 7,
  parameter bit HAS_W64   = 1'b1,
  parameter bit HAS_FLOAT = 1'b1,
  parameter bit HAS_SHORT = 1'b0,
  parameter bit HAS_VEC   = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              retire_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [XLEN-1:0]   bad_addr_i,
  input  logic              csr_we_i,
  input  logic [2:0]        csr_addr_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              trap_o,
  output logic [CODE_W-1:0] trap_code_o,
  output logic [XLEN-1:0]   trap_vec_o,
  output logic              fatal_o,
  output logic              wide_o,
  output logic              sup_o,
  output logic              vm_en_o,
  output logic              tlb_flush_o
);
  logic [XLEN-1:0]   status_q, count_q, compare_q, cause_w;
  logic [XLEN-1:0]   epc_q, evec_q, bad_q;
  logic [IRQ_W-1:0]  pend_q, pend_n;
  logic [CODE_W-1:0] code_q, take_code;
  logic              take, error, hit, fatal_q, we;

  assign we = csr_we_i && !take;  // trap cycle drops the write

  trap_decide #(
    .XLEN(XLEN), .IRQ_W(IRQ_W), .CODE_W(CODE_W),
    .NUM_TRAPS(NUM_TRAPS), .IRQ_CODE(IRQ_CODE)
  ) i_decide (
    .status_i(status_q), .pend_i(pend_q), .fatal_i(fatal_q),
    .retire_i(retire_i), .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i),
    .take_o(take), .code_o(take_code), .error_o(error)
  );

  trap_status #(
    .XLEN(XLEN), .IRQ_W(IRQ_W), .HAS_W64(HAS_W64), .HAS_FLOAT(HAS_FLOAT),
    .HAS_SHORT(HAS_SHORT), .HAS_VEC(HAS_VEC)
  ) i_status (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(we && csr_addr_i == CSR_STATUS), .wdata_i(csr_wdata_i),
    .trap_i(take), .status_o(status_q), .flush_o(tlb_flush_o)
  );

  trap_timer #(.XLEN(XLEN)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .retire_i(retire_i),
    .cnt_wr_i(we && csr_addr_i == CSR_COUNT),
    .cmp_wr_i(we && csr_addr_i == CSR_COMPARE),
    .wdata_i(csr_wdata_i), .count_o(count_q), .compare_o(compare_q), .hit_o(hit)
  );

  always_comb begin
    pend_n = pend_q;
    if (we && csr_addr_i == CSR_CAUSE) begin
      pend_n = csr_wdata_i[CA_IP_LSB +: IRQ_W];
      pend_n[TIMER_BIT] = 1'b0;  // acknowledge timer
    end
    if (hit) pend_n[TIMER_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      code_q  <= '0;
      epc_q   <= '0;
      evec_q  <= '0;
      bad_q   <= '0;
      fatal_q <= 1'b0;
    end else begin
      pend_q  <= pend_n;
      fatal_q <= fatal_q | error;
      if (take) begin
        code_q <= take_code;
        epc_q  <= pc_i;
        bad_q  <= bad_addr_i;
      end else begin
        if (we && csr_addr_i == CSR_EPC)  epc_q  <= csr_wdata_i;
        if (we && csr_addr_i == CSR_EVEC) evec_q <= csr_wdata_i;
      end
    end
  end

  always_comb begin
    cause_w = '0;
    cause_w[CODE_W-1:0] = code_q;
    cause_w[CA_IP_LSB +: IRQ_W] = pend_q;
  end

  always_comb begin
    case (csr_addr_i)
      CSR_STATUS:  csr_rdata_o = status_q;
      CSR_CAUSE:   csr_rdata_o = cause_w;
      CSR_EPC:     csr_rdata_o = epc_q;
      CSR_EVEC:    csr_rdata_o = evec_q;
      CSR_BADADDR: csr_rdata_o = bad_q;
      CSR_COUNT:   csr_rdata_o = count_q;
      CSR_COMPARE: csr_rdata_o = compare_q;
      default:     csr_rdata_o = '0;
    endcase
  end

  assign trap_o      = take;
  assign trap_code_o = take_code;
  assign trap_vec_o  = evec_q;
  assign fatal_o     = fatal_q;
  assign sup_o       = status_q[ST_SU];
  assign vm_en_o     = status_q[ST_VM];
  assign wide_o      = status_q[ST_SU] ? status_q[ST_SW] : status_q[ST_UW];
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk import trap_pkg::*; #(
  parameter int XLEN      = 32,
  parameter int IRQ_W     = 8,
  parameter int CODE_W    = 5,
  parameter int TIMER_BIT = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              retire_i,
  input logic [XLEN-1:0]   pc_i,
  input logic              exc_valid_i,
  input logic [CODE_W-1:0] exc_code_i,
  input logic              csr_we_i,
  input logic [2:0]        csr_addr_i,
  input logic              trap_o,
  input logic              fatal_o,
  input logic              tlb_flush_o,
  input logic [XLEN-1:0]   status_q,
  input logic [XLEN-1:0]   epc_q,
  input logic [XLEN-1:0]   count_q,
  input logic [XLEN-1:0]   compare_q,
  input logic [IRQ_W-1:0]  pend_q,
  input logic [CODE_W-1:0] code_q
);
  assert_no_trap_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_q[ST_TE] |-> !trap_o);

  assert_fatal_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o);

  assert_trap_status_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> (!status_q[ST_TE] && status_q[ST_SU] && status_q[ST_PS] == $past(status_q[ST_SU])));

  assert_epc_saved_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> epc_q == $past(pc_i));

  assert_timer_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retire_i && count_q == compare_q) |=> pend_q[TIMER_BIT]);

  assert_flush_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_addr_i == CSR_STATUS) |=> tlb_flush_o);

  assert_exc_priority_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && exc_valid_i) |=> code_q == $past(exc_code_i));

  assert_reserved_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_q[ST_IM_LSB-1:ST_VM+1] == '0);
endmodule

bind trap_ctrl trap_ctrl_chk #(
  .XLEN(XLEN), .IRQ_W(IRQ_W), .CODE_W(CODE_W), .TIMER_BIT(TIMER_BIT)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .retire_i(retire_i), .pc_i(pc_i),
  .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i), .csr_we_i(csr_we_i),
  .csr_addr_i(csr_addr_i), .trap_o(trap_o), .fatal_o(fatal_o),
  .tlb_flush_o(tlb_flush_o), .status_q(status_q), .epc_q(epc_q),
  .count_q(count_q), .compare_q(compare_q), .pend_q(pend_q), .code_q(code_q)
);

// File: tb/test_trap_ctrl.sv
module test_trap_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        retire_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic        exc_valid_i = 1'b0;
  logic [4:0]  exc_code_i = '0;
  logic [31:0] bad_addr_i = '0;
  logic        csr_we_i = 1'b0;
  logic [2:0]  csr_addr_i = '0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o, trap_vec_o;
  logic [4:0]  trap_code_o;
  logic        trap_o, fatal_o, wide_o, sup_o, vm_en_o, tlb_flush_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  trap_ctrl i_trap_ctrl (
    .clk_i, .rst_ni, .retire_i, .pc_i, .exc_valid_i, .exc_code_i, .bad_addr_i,
    .csr_we_i, .csr_addr_i, .csr_wdata_i, .csr_rdata_o, .trap_o, .trap_code_o,
    .trap_vec_o, .fatal_o, .wide_o, .sup_o, .vm_en_o, .tlb_flush_o
  );

  // {write data, expected status}
  localparam logic [63:0] STAT_VEC [6] = '{
    64'hFFFFFFFF_00FF01F3,
    64'h00000040_00000040,
    64'h00000080_00000080,
    64'h000000A0_000000A0,
    64'h00000020_00000020,
    64'hFF00FE0C_00000000
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
    retire_i = 1'b0;
    exc_valid_i = 1'b0;
    csr_we_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    csr_we_i = 1'b1;
    csr_addr_i = a;
    csr_wdata_i = d;
    step();
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    csr_addr_i = a;
    #1;
    d = csr_rdata_o;
  endtask

  task automatic exc(input logic [4:0] c, input logic [31:0] pc);
    exc_valid_i = 1'b1;
    exc_code_i = c;
    pc_i = pc;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    step();
    step();
    rst_ni = 1'b1;
    // R1 reset state
    rd(3'd0, v); check("R1 status", v, 32'h000000A0);
    for (int a = 1; a < 7; a++) begin
      rd(3'(a), v); check("R1 reg zero", v, 32'h0);
    end
    check("R1 fatal", {31'b0, fatal_o}, 32'd0);
    check("R1 flags", {28'b0, trap_o, wide_o, sup_o, vm_en_o}, 32'b0110);

    // R8 R9 R10 status write table
    for (int i = 0; i < 6; i++) begin
      logic [31:0] e;
      e = STAT_VEC[i][31:0];
      wr(3'd0, STAT_VEC[i][63:32]);
      check("R10 flush", {31'b0, tlb_flush_o}, 32'd1);
      check("R10 sup vm", {30'b0, sup_o, vm_en_o}, {30'b0, e[5], e[8]});
      check("R9 wide", {31'b0, wide_o}, {31'b0, e[5] ? e[7] : e[6]});
      rd(3'd0, v); check("R8 status", v, e);
    end
    step();
    check("R10 flush one cycle", {31'b0, tlb_flush_o}, 32'd0);

    // R3 R4 exception from supervisor
    wr(3'd3, 32'h100);
    wr(3'd0, 32'h00FF00A1);
    bad_addr_i = 32'h1234;
    exc(5'd3, 32'h40);
    #1;
    check("R4 redirect", {trap_o, trap_code_o, trap_vec_o[25:0]}, {1'b1, 5'd3, 26'h100});
    step();
    check("R10 flush on trap", {31'b0, tlb_flush_o}, 32'd1);
    rd(3'd0, v); check("R3 status sup", v, 32'h00FF00B0);
    rd(3'd1, v); check("R4 cause", v, 32'h00000003);
    rd(3'd2, v); check("R4 epc", v, 32'h40);
    rd(3'd4, v); check("R4 badaddr", v, 32'h1234);

    // R3 exception from user mode
    wr(3'd0, 32'h00FF0081);
    exc(5'd2, 32'h44);
    step();
    rd(3'd0, v); check("R3 status user", v, 32'h00FF00A0);

    // R6 timer
    wr(3'd0, 32'h000000A1);
    wr(3'd5, 32'd0);
    wr(3'd6, 32'd3);
    for (int k = 0; k < 3; k++) begin
      retire_i = 1'b1;
      step();
    end
    rd(3'd1, v); check("R6 no early match", v, 32'h00000002);
    retire_i = 1'b1;
    step();
    rd(3'd1, v); check("R6 timer pending", v, 32'h00800002);
    rd(3'd5, v); check("R6 count", v, 32'd4);

    // R11 exception beats interrupt
    wr(3'd0, 32'h008000A1);
    retire_i = 1'b1;
    exc(5'd4, 32'h60);
    #1;
    check("R11 code", {27'b0, trap_code_o}, 32'd4);
    step();
    rd(3'd1, v); check("R11 pending kept", v, 32'h00800004);

    // R2 interrupt
    wr(3'd0, 32'h008000A1);
    retire_i = 1'b1;
    pc_i = 32'h80;
    #1;
    check("R2 irq take", {trap_o, trap_code_o}, {26'b0, 1'b1, 5'd15});
    step();
    rd(3'd1, v); check("R2 cause", v, 32'h0080000F);
    rd(3'd2, v); check("R2 epc", v, 32'h80);

    // R7 acknowledge timer
    wr(3'd1, 32'h00FF0000);
    rd(3'd1, v); check("R7 ack", v, 32'h007F000F);
    wr(3'd0, 32'h008000A1);
    retire_i = 1'b1;
    #1;
    check("R2 masked no take", {31'b0, trap_o}, 32'd0);
    step();

    // R12 write dropped in trap cycle
    exc(5'd5, 32'h200);
    csr_we_i = 1'b1;
    csr_addr_i = 3'd2;
    csr_wdata_i = 32'hDEAD;
    step();
    rd(3'd2, v); check("R12 epc", v, 32'h200);

    // R7 match wins over cause write
    wr(3'd5, 32'd10);
    wr(3'd6, 32'd10);
    retire_i = 1'b1;
    csr_we_i = 1'b1;
    csr_addr_i = 3'd1;
    csr_wdata_i = 32'h0;
    step();
    rd(3'd1, v); check("R7 match wins", v, 32'h00800005);

    // R5 trap with trap enable clear
    exc(5'd1, 32'h300);
    #1;
    check("R5 no vector", {31'b0, trap_o}, 32'd0);
    step();
    check("R5 fatal", {31'b0, fatal_o}, 32'd1);
    rd(3'd2, v); check("R5 epc kept", v, 32'h200);
    step();
    check("R5 sticky", {31'b0, fatal_o}, 32'd1);

    // R5 out-of-range code
    rst_ni = 1'b0;
    step();
    rst_ni = 1'b1;
    check("R1 fatal cleared", {31'b0, fatal_o}, 32'd0);
    wr(3'd0, 32'h000000A1);
    exc(5'd16, 32'h400);
    #1;
    check("R5 bad code no vector", {31'b0, trap_o}, 32'd0);
    step();
    check("R5 bad code fatal", {31'b0, fatal_o}, 32'd1);
    rd(3'd1, v); check("R5 cause kept", v, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule